// File: doc/BRIEF.md
# Latched Current-Limit Gate Control

This block is the synchronous control core of a three-channel low-side gate driver that enforces a cycle-by-cycle current limit. A PWM command drives the two main gate channels. An auxiliary command drives a third, independent channel. A comparator flag reports that the sensed current is above the programmed threshold. When that happens, the block drops both main gates and raises a limit flag. The trip holds until the sense level has fallen and the PWM command starts a new period.

The second main channel can be switched off with an active-high disable. Switching it off takes effect only at the end of the current PWM pulse, so a pulse in progress is never cut short. A blanking input, active low, masks the comparator during switching transients; it is pulled high when undriven. Two supply-good flags force every gate low and clear the trip.

The slow control inputs pass through a synchronizer chain of configurable depth. After reset, the outputs are held low until that chain and the edge detector carry valid data.

Top module: `gate_limit_ctrl`

## Requirements
- R1: With no trip, supplies good and the settle window over, `gate1` follows `pwm_in`, delayed by the synchronizer depth plus one register.
- R2: `gate2` follows `pwm_in` like `gate1` while channel 2 is enabled, and stays low while it is disabled; `gate2` is never high when `gate1` is low.
- R3: Raising `ch2_off` disables channel 2 only at the next falling edge of the synchronized PWM. Lowering `ch2_off` enables channel 2 on the next cycle after synchronization.
- R4: While `blank_n` is low (synchronized), `over_thr` cannot set the trip.
- R5: With `blank_n` high, both supplies good and the settle window over, `over_thr` high sets the trip. On the next clock edge `lim_flag` goes high and `gate1` and `gate2` go low.
- R6: A trip stays set until a rising edge of the synchronized PWM occurs while `over_thr` is low. At that same edge `lim_flag` clears and `gate1` follows the PWM again.
- R7: If `over_thr` is still high when the PWM rises, the trip stays set and `lim_flag` stays high.
- R8: `gate3` follows `aux_in` with the synchronizer delay. The trip, `ch2_off` and `blank_n` have no effect on it.
- R9: If `vcc_ok` or `pvdd_ok` is low, all three gates and `lim_flag` are low at the next edge, and the trip is cleared.
- R10: During reset all outputs are low. The channel-2 enable state comes from `ch2_off` as sampled just after reset release.
- R11: For `SYNC_STAGES`+1 clock edges after reset release, all gates stay low whatever the inputs are.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Control clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pwm_in | input | 1 | Main PWM command for channels 1 and 2 (asynchronous) |
| aux_in | input | 1 | Auxiliary channel command (asynchronous) |
| ch2_off | input | 1 | Channel-2 disable, active high (asynchronous) |
| blank_n | input | 1 | Comparator blanking, active low (asynchronous) |
| over_thr | input | 1 | Comparator result: sense above threshold (synchronous) |
| vcc_ok | input | 1 | Logic supply good |
| pvdd_ok | input | 1 | Driver supply good |
| gate1 | output | 1 | Channel 1 gate command |
| gate2 | output | 1 | Channel 2 gate command |
| gate3 | output | 1 | Auxiliary gate command |
| lim_flag | output | 1 | Current-limit trip flag |

## Verification
The bench builds the block with `SYNC_STAGES` set to 3 instead of the default 2. This lengthens both the input latency and the post-reset settle window. It confirms that the settle counter and the edge detector scale with the chain depth rather than with a fixed count. All checks sample after a wait longer than the deepest latency, except the trip and supply checks. Those are timed to the single edge that `over_thr`, `vcc_ok` and `pvdd_ok` take to reach the outputs, so any extra delay in that path becomes visible.

// File: rtl/gate_limit_pkg.sv
package gate_limit_pkg;

  // Asynchronous control inputs carried through the synchronizer as one bundle
  typedef struct packed {
    logic pwm;
    logic aux;
    logic ch2_off;
    logic blank_n;
  } ctl_in_t;

  localparam int unsigned CTL_W = $bits(ctl_in_t);

  // Reset image of the bundle: blanking asserted (blank_n low), all else low
  localparam ctl_in_t CTL_RST = '{pwm: 1'b0, aux: 1'b0, ch2_off: 1'b0, blank_n: 1'b0};

endpackage

// File: rtl/gate_limit_sync.sv
module gate_limit_sync #(
  parameter int unsigned WIDTH  = 4,
  parameter int unsigned STAGES = 2,
  parameter logic [WIDTH-1:0] RST_VAL = '0
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);

  logic [STAGES-1:0][WIDTH-1:0] chain_q;
  logic [STAGES-1:0][WIDTH-1:0] chain_d;

  always_comb begin
    chain_d[0] = d;
    for (int i = 1; i < STAGES; i++) begin
      chain_d[i] = chain_q[i-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chain_q <= {STAGES{RST_VAL}};
    end else begin
      chain_q <= chain_d;
    end
  end

  assign q = chain_q[STAGES-1];

endmodule

// File: rtl/gate_limit_edge.sv
module gate_limit_edge (
  input  logic clk,
  input  logic rst_n,
  input  logic track,
  input  logic sig,
  output logic rise,
  output logic fall
);

  logic prev_q;
  logic prev_d;

  always_comb begin
    prev_d = prev_q;
    if (track) begin
      prev_d = sig;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_q <= 1'b0;
    end else begin
      prev_q <= prev_d;
    end
  end

  assign rise = track &  sig & ~prev_q;
  assign fall = track & ~sig &  prev_q;

endmodule

// File: rtl/gate_limit_trip.sv
module gate_limit_trip (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic supply_ok,
  input  logic blank_n_s,
  input  logic over_thr,
  input  logic pwm_rise,
  output logic trip_d,
  output logic trip_q
);

  logic arm;
  logic release_ok;

  assign arm        = ready & blank_n_s & over_thr;
  assign release_ok = trip_q & pwm_rise & ~over_thr;

  always_comb begin
    trip_d = trip_q;
    if (!supply_ok) begin
      trip_d = 1'b0;
    end else if (arm) begin
      trip_d = 1'b1;
    end else if (release_ok) begin
      trip_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trip_q <= 1'b0;
    end else begin
      trip_q <= trip_d;
    end
  end

endmodule

// File: rtl/gate_limit_ch2.sv
module gate_limit_ch2 (
  input  logic clk,
  input  logic rst_n,
  input  logic ready,
  input  logic ch2_off_s,
  input  logic pwm_fall,
  output logic en_d,
  output logic en_q
);

  always_comb begin
    en_d = en_q;
    if (!ready) begin
      en_d = ~ch2_off_s;
    end else if (!ch2_off_s) begin
      en_d = 1'b1;
    end else if (pwm_fall) begin
      en_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q <= 1'b0;
    end else begin
      en_q <= en_d;
    end
  end

endmodule

// File: rtl/gate_limit_ctrl.sv
module gate_limit_ctrl
  import gate_limit_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic pwm_in,
  input  logic aux_in,
  input  logic ch2_off,
  input  logic blank_n,
  input  logic over_thr,
  input  logic vcc_ok,
  input  logic pvdd_ok,
  output logic gate1,
  output logic gate2,
  output logic gate3,
  output logic lim_flag
);

  localparam int unsigned SETTLE = SYNC_STAGES + 1;
  localparam int unsigned CNT_W  = $clog2(SETTLE + 1);

  ctl_in_t raw_in;
  ctl_in_t syn_in;
  logic [CTL_W-1:0] syn_vec;

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic cnt_en;
  logic ready;
  logic supply_ok;
  logic pwm_rise, pwm_fall;
  logic trip_d, trip_q;
  logic en2_d, en2_q;
  logic g1_d, g2_d, g3_d;
  logic g1_q, g2_q, g3_q;

  assign raw_in = '{pwm: pwm_in, aux: aux_in, ch2_off: ch2_off, blank_n: blank_n};

  gate_limit_sync #(
    .WIDTH  (CTL_W),
    .STAGES (SYNC_STAGES),
    .RST_VAL(CTL_RST)
  ) sync_i (
    .clk  (clk),
    .rst_n(rst_n),
    .d    (raw_in),
    .q    (syn_vec)
  );

  assign syn_in = ctl_in_t'(syn_vec);

  // Settle window: hold gates low until the chain and edge history are valid
  assign ready  = (cnt_q == CNT_W'(SETTLE));
  assign cnt_en = ~ready;

  always_comb begin
    cnt_d = cnt_q;
    if (cnt_en) begin
      cnt_d = cnt_q + CNT_W'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end

  assign supply_ok = vcc_ok & pvdd_ok;

  gate_limit_edge edge_i (
    .clk  (clk),
    .rst_n(rst_n),
    .track(1'b1),
    .sig  (syn_in.pwm),
    .rise (pwm_rise),
    .fall (pwm_fall)
  );

  gate_limit_trip trip_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .supply_ok(supply_ok),
    .blank_n_s(syn_in.blank_n),
    .over_thr (over_thr),
    .pwm_rise (pwm_rise & ready),
    .trip_d   (trip_d),
    .trip_q   (trip_q)
  );

  gate_limit_ch2 ch2_i (
    .clk      (clk),
    .rst_n    (rst_n),
    .ready    (ready),
    .ch2_off_s(syn_in.ch2_off),
    .pwm_fall (pwm_fall),
    .en_d     (en2_d),
    .en_q     (en2_q)
  );

  // Gate next state: the trip's next value blocks the main pair on the same edge
  always_comb begin
    g1_d = ready & supply_ok & syn_in.pwm & ~trip_d;
    g2_d = g1_d & en2_d;
    g3_d = ready & supply_ok & syn_in.aux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g1_q <= 1'b0;
      g2_q <= 1'b0;
      g3_q <= 1'b0;
    end else begin
      g1_q <= g1_d;
      g2_q <= g2_d;
      g3_q <= g3_d;
    end
  end

  assign gate1    = g1_q;
  assign gate2    = g2_q;
  assign gate3    = g3_q;
  assign lim_flag = trip_q;

endmodule

// File: rtl/gate_limit_chk.sv
module gate_limit_chk (
  input logic clk,
  input logic rst_n,
  input logic ready,
  input logic blank_n_s,
  input logic pwm_s,
  input logic aux_s,
  input logic pwm_rise,
  input logic over_thr,
  input logic vcc_ok,
  input logic pvdd_ok,
  input logic gate1,
  input logic gate2,
  input logic gate3,
  input logic lim_flag
);

  // R5: an unblanked over-threshold trips on the next edge
  a_r5_trip_sets: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && vcc_ok && pvdd_ok && blank_n_s && over_thr) |=> (lim_flag && !gate1 && !gate2));

  // R4: blanking keeps a clear trip clear
  a_r4_blank_masks: assert property (@(posedge clk) disable iff (!rst_n)
    (!lim_flag && !blank_n_s) |=> !lim_flag);

  // R6: the trip holds without a PWM rising edge
  a_r6_trip_holds: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_flag && vcc_ok && pvdd_ok && !pwm_rise) |=> lim_flag);

  // R7: the trip holds across a rise while still above threshold
  a_r7_no_release_high: assert property (@(posedge clk) disable iff (!rst_n)
    (lim_flag && vcc_ok && pvdd_ok && over_thr) |=> lim_flag);

  // R9: a supply fault clears every output
  a_r9_supply_off: assert property (@(posedge clk) disable iff (!rst_n)
    !(vcc_ok && pvdd_ok) |=> (!gate1 && !gate2 && !gate3 && !lim_flag));

  // R2: channel 2 never drives without channel 1
  a_r2_gate2_subset: assert property (@(posedge clk) disable iff (!rst_n)
    gate2 |-> gate1);

  // R5: a raised flag means both main gates are low
  a_r5_flag_blocks: assert property (@(posedge clk) disable iff (!rst_n)
    lim_flag |-> (!gate1 && !gate2));

  // R8: the auxiliary gate tracks its synchronized command
  a_r8_aux_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && vcc_ok && pvdd_ok) |=> (gate3 == $past(aux_s)));

  // R11: nothing drives before the settle window ends
  a_r11_settle_low: assert property (@(posedge clk) disable iff (!rst_n)
    !ready |=> (!gate1 && !gate2 && !gate3));

  // R1: with no trip, gate1 tracks the synchronized PWM
  a_r1_gate1_follows: assert property (@(posedge clk) disable iff (!rst_n)
    (ready && vcc_ok && pvdd_ok && !over_thr && !lim_flag && !pwm_rise) |=> (gate1 == $past(pwm_s)));

endmodule

bind gate_limit_ctrl gate_limit_chk chk_i (
  .clk      (clk),
  .rst_n    (rst_n),
  .ready    (ready),
  .blank_n_s(syn_in.blank_n),
  .pwm_s    (syn_in.pwm),
  .aux_s    (syn_in.aux),
  .pwm_rise (pwm_rise),
  .over_thr (over_thr),
  .vcc_ok   (vcc_ok),
  .pvdd_ok  (pvdd_ok),
  .gate1    (gate1),
  .gate2    (gate2),
  .gate3    (gate3),
  .lim_flag (lim_flag)
);

// File: tb/gate_limit_ctrl_tb_top.sv
module gate_limit_ctrl_tb_top;

  localparam int unsigned STAGES = 3;
  localparam int unsigned LONG   = STAGES + 4;

  logic clk = 1'b0;
  logic rst_n, pwm_in, aux_in, ch2_off, blank_n, over_thr, vcc_ok, pvdd_ok;
  logic gate1, gate2, gate3, lim_flag;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  typedef struct {
    string tag;
    logic  g1, g2, g3, f;
  } exp_t;

  exp_t sb[$];

  always #5 clk = ~clk;

  gate_limit_ctrl #(.SYNC_STAGES(STAGES)) dut_i (
    .clk(clk), .rst_n(rst_n), .pwm_in(pwm_in), .aux_in(aux_in), .ch2_off(ch2_off),
    .blank_n(blank_n), .over_thr(over_thr), .vcc_ok(vcc_ok), .pvdd_ok(pvdd_ok),
    .gate1(gate1), .gate2(gate2), .gate3(gate3), .lim_flag(lim_flag)
  );

  // Driver side: wait n edges, then post the expectation for the monitor
  task automatic settle_and_expect(input int n, input string tag,
                                   input logic g1, input logic g2, input logic g3, input logic f);
    exp_t e;
    repeat (n) @(posedge clk);
    #1;
    e.tag = tag; e.g1 = g1; e.g2 = g2; e.g3 = g3; e.f = f;
    sb.push_back(e);
    wait (sb.size() == 0);
  endtask

  task automatic at_neg();
    @(negedge clk);
  endtask

  // Monitor: pop each expectation and compare it against the ports
  initial begin
    forever begin
      exp_t e;
      wait (sb.size() != 0);
      e = sb.pop_front();
      checks++;
      if ({gate1, gate2, gate3, lim_flag} !== {e.g1, e.g2, e.g3, e.f}) begin
        errors++;
        $display("FAIL %s: got g1g2g3f=%b%b%b%b expected %b%b%b%b",
                 e.tag, gate1, gate2, gate3, lim_flag, e.g1, e.g2, e.g3, e.f);
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; pwm_in = 1'b1; aux_in = 1'b1; ch2_off = 1'b0; blank_n = 1'b1;
    over_thr = 1'b0; vcc_ok = 1'b1; pvdd_ok = 1'b1;
    settle_and_expect(3, "R10 reset outputs low", 0, 0, 0, 0);
    at_neg(); rst_n = 1'b1;
    settle_and_expect(2, "R11 held low in settle window", 0, 0, 0, 0);
    settle_and_expect(LONG, "R1 gate1 follows high pwm, R10 ch2 enabled", 1, 1, 1, 0);

    at_neg(); pwm_in = 1'b0;
    settle_and_expect(LONG, "R1 gate1 follows low pwm", 0, 0, 1, 0);
    at_neg(); aux_in = 1'b0; pwm_in = 1'b1;
    settle_and_expect(LONG, "R8 aux low, R2 gate2 follows", 1, 1, 0, 0);

    // Trip and latch
    at_neg(); over_thr = 1'b1;
    settle_and_expect(1, "R5 trip one edge after over_thr", 0, 0, 0, 1);
    at_neg(); aux_in = 1'b1; ch2_off = 1'b1; blank_n = 1'b0;
    settle_and_expect(LONG, "R8 aux unaffected by trip/ch2_off/blank", 0, 0, 1, 1);
    at_neg(); ch2_off = 1'b0; blank_n = 1'b1; over_thr = 1'b0;
    settle_and_expect(LONG, "R6 trip held without pwm rise", 0, 0, 1, 1);
    at_neg(); pwm_in = 1'b0;
    settle_and_expect(LONG, "R6 trip held through pwm fall", 0, 0, 1, 1);
    at_neg(); over_thr = 1'b1; pwm_in = 1'b1;
    settle_and_expect(LONG, "R7 no release with over_thr high", 0, 0, 1, 1);
    at_neg(); over_thr = 1'b0; pwm_in = 1'b0;
    settle_and_expect(LONG, "R6 still tripped at pwm low", 0, 0, 1, 1);
    at_neg(); pwm_in = 1'b1;
    settle_and_expect(STAGES + 1, "R6 release on pwm rise", 1, 1, 1, 0);

    // Blanking
    at_neg(); blank_n = 1'b0;
    settle_and_expect(LONG, "R4 blank settle", 1, 1, 1, 0);
    at_neg(); over_thr = 1'b1;
    settle_and_expect(LONG, "R4 no trip while blanked", 1, 1, 1, 0);
    at_neg(); over_thr = 1'b0; blank_n = 1'b1;
    settle_and_expect(LONG, "R4 unblank with sense low", 1, 1, 1, 0);

    // Deferred channel 2 disable
    at_neg(); ch2_off = 1'b1;
    settle_and_expect(LONG, "R3 gate2 kept until pwm falls", 1, 1, 1, 0);
    at_neg(); pwm_in = 1'b0;
    settle_and_expect(LONG, "R3 disable at pwm fall", 0, 0, 1, 0);
    at_neg(); pwm_in = 1'b1;
    settle_and_expect(LONG, "R2 gate2 low when disabled", 1, 0, 1, 0);
    at_neg(); ch2_off = 1'b0;
    settle_and_expect(LONG, "R3 enable without pwm edge", 1, 1, 1, 0);

    // Supply faults
    at_neg(); over_thr = 1'b1;
    settle_and_expect(1, "R5 trip before supply fault", 0, 0, 1, 1);
    at_neg(); vcc_ok = 1'b0;
    settle_and_expect(1, "R9 vcc fault clears all", 0, 0, 0, 0);
    at_neg(); over_thr = 1'b0; vcc_ok = 1'b1;
    settle_and_expect(1, "R9 trip cleared after vcc returns", 1, 1, 1, 0);
    at_neg(); pvdd_ok = 1'b0;
    settle_and_expect(1, "R9 pvdd fault clears all", 0, 0, 0, 0);
    at_neg(); pvdd_ok = 1'b1;
    settle_and_expect(1, "R9 pvdd return", 1, 1, 1, 0);

    // Reset with channel 2 disabled
    at_neg(); rst_n = 1'b0; ch2_off = 1'b1;
    settle_and_expect(2, "R10 reset clears outputs", 0, 0, 0, 0);
    at_neg(); rst_n = 1'b1;
    settle_and_expect(LONG + 2, "R10 ch2 disabled from reset sample", 1, 0, 1, 0);

    done = 1'b1;
    #1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

endmodule